// File: doc/BRIEF.md
# Endpoint Interrupt Status Latch with Clear-on-Read

This block holds the sticky interrupt status for the control endpoint and three IN endpoints of a USB device controller. It watches the handshake flags that each endpoint's logic already produces and turns selected transitions into single-cycle events. Each event latches one status bit until software reads the register. A summary interrupt line tells the processor that at least one bit is set.

Software reads a 32-bit word at a fixed offset through a plain read port made of an address, a strobe and read data. The port has no back-pressure. It always accepts a read, and it returns data in the same cycle as the strobe. That read returns the bits as they stood before the read, and it clears them all on the clock edge that ends the strobe. The block has no write port, so no write can change its state. Status is also kept in sibling OUT and bus-level registers outside this block, and servicing an interrupt in full means reading those as well, with the bus-level register read last.

Top module: `ep_irq_latch`

## Requirements
- R1: After reset every status bit is 0, the summary interrupt is 0, and a read at the status offset returns 32'h0.
- R2: Bit 0 of the read word is the control endpoint, and bit k (k = 1..3) is IN endpoint k, driven through `in_*[k-1]`. Bits 31:4 always read as 0.
- R3: The control bit sets on any one of these: `ctl_out_rdy` rises, `ctl_in_rdy` falls, `ctl_stall_sent` rises, `ctl_setup_end` rises, or `ctl_data_end` falls. The opposite transitions set nothing.
- R4: An IN endpoint bit sets when that endpoint's `in_pkt_rdy` falls, when its `in_fifo_flush` rises, or when its `in_stall_sent` rises. A rise of `in_pkt_rdy` sets nothing.
- R5: Flags are edge-detected against their value one clock earlier. A flag that stays at a level does not set the bit again after it has been cleared.
- R6: A read with `rd_en`=1 and `rd_addr`=12'h008 returns the status in the same cycle and clears all bits on that clock edge.
- R7: A read at any other address returns 0 and leaves the status unchanged. `rd_data` is 0 whenever no matching read is in progress.
- R8: An event that coincides with a clearing read leaves its bit set after the read.
- R9: `irq` is the registered OR of the status bits. It rises one cycle after a bit sets, and it falls one cycle after a clearing read unless a bit was set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_out_rdy | input | 1 | Control endpoint: OUT packet received flag |
| ctl_in_rdy | input | 1 | Control endpoint: IN packet loaded flag |
| ctl_stall_sent | input | 1 | Control endpoint: STALL handshake sent flag |
| ctl_setup_end | input | 1 | Control endpoint: setup ended early flag |
| ctl_data_end | input | 1 | Control endpoint: last data packet flag |
| in_pkt_rdy | input | NUM_IN_EP | Per IN endpoint: packet loaded flag |
| in_fifo_flush | input | NUM_IN_EP | Per IN endpoint: FIFO flush indication |
| in_stall_sent | input | NUM_IN_EP | Per IN endpoint: STALL sent to an IN token |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Read data, valid in the strobe cycle |
| irq | output | 1 | Summary interrupt |

## Verification
The bench builds the block with its default parameters: three IN endpoints, a 12-bit offset, a 32-bit word and the status at offset 12'h008. With these values every bit position and every reserved bit can be seen in one read word. The bench can drive each control and IN flag transition on its own and compare the result against a read at a neighbouring offset. It can also line a flag edge up exactly with the clearing read to exercise the overlap rule.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
  // bit position of the control endpoint in the status word
  localparam int CTL_POS = 0;
  // control flags split by the transition that counts as an event
  localparam int CTL_RISE_N = 3; // out_rdy, stall_sent, setup_end
  localparam int CTL_FALL_N = 2; // in_rdy, data_end
  typedef enum logic { EDGE_RISE = 1'b0, EDGE_FALL = 1'b1 } edge_kind_e;
endpackage

// File: rtl/ep_edge_det.sv
module ep_edge_det
  import ep_irq_pkg::*;
#(
  parameter int         W    = 1,
  parameter edge_kind_e KIND = EDGE_RISE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] pulse
);
  logic [W-1:0] d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= '0;
    else        d_q <= d;
  end

  generate
    if (KIND == EDGE_RISE) begin : g_rise
      assign pulse = d & ~d_q;
    end else begin : g_fall
      assign pulse = ~d & d_q;
    end
  endgenerate
endmodule

// File: rtl/ep_irq_status.sv
module ep_irq_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic         clr,
  output logic [N-1:0] stat
);
  // a set in the clearing cycle wins, so no event is dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stat <= '0;
    else if (clr) stat <= set_evt;
    else          stat <= stat | set_evt;
  end
endmodule

// File: rtl/ep_irq_rdport.sv
module ep_irq_rdport #(
  parameter int          ADDR_W = 12,
  parameter int          DATA_W = 32,
  parameter int          N      = 4,
  parameter logic [11:0] OFFSET = 12'h008
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [N-1:0]      stat,
  output logic              hit,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(OFFSET);

  assign hit = rd_en && (rd_addr == OFS);

  always_comb begin
    rd_data = '0;
    if (hit) rd_data[N-1:0] = stat;
  end
endmodule

// File: rtl/ep_irq_latch.sv
module ep_irq_latch
  import ep_irq_pkg::*;
#(
  parameter int          NUM_IN_EP = 3,
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 32,
  parameter logic [11:0] OFFSET    = 12'h008
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_out_rdy,
  input  logic                 ctl_in_rdy,
  input  logic                 ctl_stall_sent,
  input  logic                 ctl_setup_end,
  input  logic                 ctl_data_end,
  input  logic [NUM_IN_EP-1:0] in_pkt_rdy,
  input  logic [NUM_IN_EP-1:0] in_fifo_flush,
  input  logic [NUM_IN_EP-1:0] in_stall_sent,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 irq
);
  localparam int NB = NUM_IN_EP + 1;

  logic [CTL_RISE_N-1:0] ctl_rise;
  logic [CTL_FALL_N-1:0] ctl_fall;
  logic [NUM_IN_EP-1:0]  pkt_fall, flush_rise, stall_rise;
  logic [NB-1:0]         evt;
  logic [NB-1:0]         stat_q;
  logic                  rd_hit;

  ep_edge_det #(.W(CTL_RISE_N), .KIND(EDGE_RISE)) u_ctl_rise (
    .clk(clk), .rst_n(rst_n),
    .d({ctl_setup_end, ctl_stall_sent, ctl_out_rdy}), .pulse(ctl_rise));

  ep_edge_det #(.W(CTL_FALL_N), .KIND(EDGE_FALL)) u_ctl_fall (
    .clk(clk), .rst_n(rst_n),
    .d({ctl_data_end, ctl_in_rdy}), .pulse(ctl_fall));

  ep_edge_det #(.W(NUM_IN_EP), .KIND(EDGE_FALL)) u_pkt_fall (
    .clk(clk), .rst_n(rst_n), .d(in_pkt_rdy), .pulse(pkt_fall));

  ep_edge_det #(.W(NUM_IN_EP), .KIND(EDGE_RISE)) u_flush_rise (
    .clk(clk), .rst_n(rst_n), .d(in_fifo_flush), .pulse(flush_rise));

  ep_edge_det #(.W(NUM_IN_EP), .KIND(EDGE_RISE)) u_stall_rise (
    .clk(clk), .rst_n(rst_n), .d(in_stall_sent), .pulse(stall_rise));

  assign evt[CTL_POS] = |ctl_rise | |ctl_fall;

  generate
    for (genvar k = 0; k < NUM_IN_EP; k++) begin : g_in_evt
      assign evt[k+1] = pkt_fall[k] | flush_rise[k] | stall_rise[k];
    end
  endgenerate

  ep_irq_status #(.N(NB)) u_status (
    .clk(clk), .rst_n(rst_n), .set_evt(evt), .clr(rd_hit), .stat(stat_q));

  ep_irq_rdport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N(NB), .OFFSET(OFFSET)) u_rd (
    .rd_en(rd_en), .rd_addr(rd_addr), .stat(stat_q), .hit(rd_hit), .rd_data(rd_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |stat_q;
  end
endmodule

// File: rtl/ep_irq_latch_chk.sv
module ep_irq_latch_chk #(
  parameter int          NB     = 4,
  parameter int          ADDR_W = 12,
  parameter int          DATA_W = 32,
  parameter logic [11:0] OFFSET = 12'h008
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq,
  input logic [NB-1:0]     evt,
  input logic [NB-1:0]     stat_q
);
  logic hit;
  assign hit = rd_en && (rd_addr == ADDR_W'(OFFSET));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:NB] == '0);

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> rd_data == '0);

  // R7
  miss_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (stat_q & $past(stat_q)) == $past(stat_q));

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> stat_q == $past(evt));

  // R8
  event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> (stat_q & $past(evt)) == $past(evt));

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 irq == $past(stat_q != '0));
endmodule

bind ep_irq_latch ep_irq_latch_chk #(
  .NB(NUM_IN_EP + 1), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(OFFSET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_data(rd_data), .irq(irq), .evt(evt), .stat_q(stat_q)
);

// File: tb/ep_irq_latch_tb.sv
`timescale 1ns/1ps
module ep_irq_latch_tb;
  localparam int NEP = 3;
  localparam logic [11:0] OFS = 12'h008;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_out_rdy = 0, ctl_in_rdy = 0, ctl_stall_sent = 0, ctl_setup_end = 0, ctl_data_end = 0;
  logic [NEP-1:0] in_pkt_rdy = '0, in_fifo_flush = '0, in_stall_sent = '0;
  logic rd_en = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ep_irq_latch u_dut (
    .clk(clk), .rst_n(rst_n),
    .ctl_out_rdy(ctl_out_rdy), .ctl_in_rdy(ctl_in_rdy), .ctl_stall_sent(ctl_stall_sent),
    .ctl_setup_end(ctl_setup_end), .ctl_data_end(ctl_data_end),
    .in_pkt_rdy(in_pkt_rdy), .in_fifo_flush(in_fifo_flush), .in_stall_sent(in_stall_sent),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one read cycle; data sampled mid-cycle, clear happens at the next edge
  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0; rd_addr = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(OFS, d);
    chk("R1 status after reset", d, 32'h0);
  endtask

  task automatic t_ctl();
    logic [31:0] d;
    ctl_in_rdy = 1; ctl_data_end = 1; step();
    rd(OFS, d); chk("R3 rising in_rdy/data_end no event", d, 32'h0);
    ctl_out_rdy = 1; step(); rd(OFS, d); chk("R3 out_rdy rise", d, 32'h1);
    ctl_out_rdy = 0; step(); rd(OFS, d); chk("R3 out_rdy fall no event", d, 32'h0);
    ctl_in_rdy = 0; step(); rd(OFS, d); chk("R3 in_rdy fall", d, 32'h1);
    ctl_stall_sent = 1; step(); rd(OFS, d); chk("R3 stall rise", d, 32'h1);
    ctl_stall_sent = 0;
    ctl_setup_end = 1; step(); rd(OFS, d); chk("R3 setup_end rise", d, 32'h1);
    ctl_setup_end = 0;
    ctl_data_end = 0; step(); rd(OFS, d); chk("R3 data_end fall", d, 32'h1);
    rd(OFS, d); chk("R3 quiet after falls", d, 32'h0);
  endtask

  task automatic t_in();
    logic [31:0] d;
    for (int k = 0; k < NEP; k++) begin
      in_pkt_rdy[k] = 1; step(); rd(OFS, d); chk("R4 pkt_rdy rise no event", d, 32'h0);
      in_pkt_rdy[k] = 0; step(); rd(OFS, d); chk("R4 pkt_rdy fall", d, 32'h1 << (k+1));
      in_fifo_flush[k] = 1; step(); in_fifo_flush[k] = 0;
      rd(OFS, d); chk("R4 flush", d, 32'h1 << (k+1));
      in_stall_sent[k] = 1; step(); rd(OFS, d); chk("R4 stall rise", d, 32'h1 << (k+1));
      in_stall_sent[k] = 0; step(); rd(OFS, d); chk("R4 stall fall no event", d, 32'h0);
    end
  endtask

  task automatic t_level();
    logic [31:0] d;
    in_stall_sent[2] = 1; ctl_setup_end = 1; step();
    rd(OFS, d); chk("R5 first edge", d, 32'h9);
    repeat (4) step();
    rd(OFS, d); chk("R5 held level no re-set", d, 32'h0);
    chk("R5 irq idle with held level", {31'b0, irq}, 32'h0);
    in_stall_sent[2] = 0; ctl_setup_end = 0; step();
  endtask

  task automatic t_miss();
    logic [31:0] d;
    in_fifo_flush[1] = 1; step(); in_fifo_flush[1] = 0;
    rd(12'h00C, d); chk("R7 other offset reads 0", d, 32'h0);
    rd(12'h000, d); chk("R7 offset 0 reads 0", d, 32'h0);
    rd(OFS, d); chk("R7 status kept after miss", d, 32'h4);
  endtask

  task automatic t_multi();
    logic [31:0] d;
    ctl_out_rdy = 1; in_stall_sent = '1; step();
    rd(OFS, d);
    chk("R2 all four bits", d, 32'hF);
    chk("R2 reserved bits zero", {4'h0, d[31:4]}, 32'h0);
    rd(OFS, d); chk("R6 cleared by read", d, 32'h0);
    ctl_out_rdy = 0; in_stall_sent = '0; step();
  endtask

  task automatic t_same();
    logic [31:0] d;
    ctl_stall_sent = 1; step(); ctl_stall_sent = 0;
    // read and a new IN1 event in the same cycle
    @(negedge clk);
    rd_en = 1; rd_addr = OFS; in_stall_sent[0] = 1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 0;
    chk("R6 pre-clear value returned", d, 32'h1);
    rd(OFS, d); chk("R8 coinciding event kept", d, 32'h2);
    in_stall_sent[0] = 0; step();
  endtask

  task automatic t_irq();
    logic [31:0] d;
    in_pkt_rdy[1] = 1; step();
    in_pkt_rdy[1] = 0;           // event seen at next edge
    step();                      // status set, irq not yet
    chk("R9 irq lags status", {31'b0, irq}, 32'h0);
    step();
    chk("R9 irq asserted", {31'b0, irq}, 32'h1);
    rd_en = 1; rd_addr = OFS;    // clear at next edge
    #1 d = rd_data;
    @(negedge clk); rd_en = 0;
    chk("R9 read data before clear", d, 32'h4);
    chk("R9 irq one cycle after read", {31'b0, irq}, 32'h1);
    step();
    chk("R9 irq dropped", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_ctl();
    t_in();
    t_level();
    t_miss();
    t_multi();
    t_same();
    t_irq();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule